// File: doc/BRIEF.md
# Periodic Tick Timer with Cross-Domain Configuration

This block produces a steady stream of timeout events. The timing path runs on a reference clock. A power-of-two prescaler (divide by 1, 16 or 256) feeds an 8-bit modulus down counter. Each time the counter wraps, the block records a timeout. The next period starts on the following prescaled tick, so no time is lost between periods.

The register side runs on a separate bus clock. It holds the timeout flag, the interrupt enable, the three freeze-policy bits and the period configuration. A new rate/count pair is passed to the reference domain through a toggle request/acknowledge handshake. The counter adopts the new pair at the start of its next period, or at once if it is idle. While that transfer is in flight, a busy output is high and further configuration writes are dropped.

Three mode inputs (wait, stop, debug) can each freeze the prescaler and counter, depending on their policy bits. While frozen, the counter keeps its place and resumes from where it stopped.

Top module: `periodic_tick_timer`

## Requirements
- R1: The rate field `cfg_rate` selects the prescale ratio: 01 divides by 1, 10 by 16 and 11 by 256. A count value N (0 to 255) gives a period of (N+1) times the ratio, in reference-clock cycles.
- R2: Periods follow each other back to back: successive flag-set events are exactly one period apart.
- R3: When the adopted rate field is 00, the counter is idle and the flag is never set.
- R4: `irq_req` is high exactly when `timeout_flag` is high and the interrupt enable bit (written through `ctl_we`/`ctl_irq_en`) is 1.
- R5: A cycle with `flag_clr` = 1 clears the flag on the next bus-clock edge. A set event in the same cycle wins over the clear.
- R6: With `wait_mode` = 1, the counter is frozen if the wait-freeze bit is 1 and keeps running if it is 0.
- R7: With `stop_mode` = 1, the counter keeps running if the stop-run bit is 1 and is frozen if it is 0.
- R8: With `debug_mode` = 1, the counter is frozen if the debug-freeze bit is 1 and keeps running if it is 0.
- R9: An accepted configuration write raises `cfg_busy` on the next bus-clock edge. Writes made while busy is high are ignored. The new pair takes effect at the end of the current period, or within a few reference cycles if the counter is idle. After that, busy falls.
- R10: After reset, the flag, the request and busy are all low, and the adopted rate is 00 (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register-side clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_ref | input | 1 | Reference clock for prescaler and counter |
| rst_ref | input | 1 | Synchronous active-high reset, reference domain |
| cfg_we | input | 1 | Write strobe for the rate/count pair |
| cfg_rate | input | 2 | Rate field (00 idle, 01 /1, 10 /16, 11 /256) |
| cfg_count | input | 8 | Count value N, period N+1 prescaled ticks |
| ctl_we | input | 1 | Write strobe for the enable and freeze-policy bits |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_wait_freeze | input | 1 | 1: freeze while in wait mode |
| ctl_stop_run | input | 1 | 1: keep running while in stop mode |
| ctl_dbg_freeze | input | 1 | 1: freeze while in debug mode |
| flag_clr | input | 1 | Write-one clear of the timeout flag |
| wait_mode | input | 1 | Wait mode active (reference-clock synchronous) |
| stop_mode | input | 1 | Stop mode active (reference-clock synchronous) |
| debug_mode | input | 1 | Debug mode active (reference-clock synchronous) |
| timeout_flag | output | 1 | Sticky timeout flag |
| irq_req | output | 1 | Interrupt request |
| cfg_busy | output | 1 | Configuration transfer in flight |

## Verification
The assertions assume the bus clock is faster than the reference clock, so every toggle crossing toward the bus is seen. They also assume the mode inputs are synchronous to the reference clock and the control bits are quasi-static. The bench runs the bus at 200 MHz and the reference clock at 25 MHz, phase-shifted so that no reference edge ever coincides with a bus edge. All stimulus changes on bus falling edges, which keeps mode inputs clear of reference edges. Configuration is written only through the normal strobe, and the flag is cleared with one-cycle pulses except in the deliberate overlap test.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;
    localparam int RATE_W    = 2;
    localparam int CNT_W     = 8;
    localparam int SHIFT_MID = 4;
    localparam int SHIFT_TOP = 8;
    localparam int PRESC_W   = SHIFT_TOP;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [RATE_W-1:0] {
        RATE_OFF    = 2'b00,
        RATE_DIV1   = 2'b01,
        RATE_DIVMID = 2'b10,
        RATE_DIVTOP = 2'b11
    } rate_e;

    typedef struct packed {
        rate_e            rate;
        logic [CNT_W-1:0] count;
    } period_cfg_t;

    typedef struct packed {
        logic wait_freeze;
        logic stop_run;
        logic dbg_freeze;
    } freeze_ctl_t;

    // Terminal value of the prescaler accumulator for a given rate.
    function automatic logic [PRESC_W-1:0] presc_limit(rate_e r);
        case (r)
            RATE_DIVMID: return PRESC_W'((1 << SHIFT_MID) - 1);
            RATE_DIVTOP: return PRESC_W'((1 << SHIFT_TOP) - 1);
            default:     return '0;
        endcase
    endfunction

    // Freeze decision from the policy bits and the mode inputs.
    function automatic logic freeze_now(freeze_ctl_t c, logic w, logic s, logic d);
        return (w && c.wait_freeze) || (s && !c.stop_run) || (d && c.dbg_freeze);
    endfunction
endpackage

// File: rtl/tick_sync.sv
`timescale 1ns/1ps
module tick_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] acc;

    assign tick = run && (acc == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) acc <= '0;
        else if (run)       acc <= tick ? '0 : acc + 1'b1;
    end

    // R1: the accumulator never passes the terminal value of the ratio in use
    a_r1_presc_in_range: assert property (@(posedge clk) disable iff (rst)
        acc <= limit);
endmodule

// File: rtl/tick_ref_core.sv
`timescale 1ns/1ps
module tick_ref_core
    import tick_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  period_cfg_t cfg_hold,
    input  logic        req_tgl,
    input  freeze_ctl_t fctl_bus,
    input  logic        wait_mode,
    input  logic        stop_mode,
    input  logic        debug_mode,
    output logic        ack_tgl,
    output logic        end_tgl
);
    localparam int FCTL_W = $bits(freeze_ctl_t);

    logic              req_s;
    logic [FCTL_W-1:0] fctl_raw;
    freeze_ctl_t       fctl;
    period_cfg_t       active;
    logic [CNT_W-1:0]  cnt;
    logic              stopped, run, pending, tick, period_end, load;

    tick_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_tgl), .q(req_s));
    tick_sync #(.W(FCTL_W), .STAGES(SYNC_STAGES)) u_fctl_sync (
        .clk(clk), .rst(rst), .d(fctl_bus), .q(fctl_raw));

    assign fctl       = freeze_ctl_t'(fctl_raw);
    assign stopped    = (active.rate == RATE_OFF);
    assign run        = !stopped && !freeze_now(fctl, wait_mode, stop_mode, debug_mode);
    assign pending    = (req_s != ack_tgl);
    assign period_end = tick && (cnt == '0);
    assign load       = pending && (stopped || period_end);

    tick_prescaler #(.W(PRESC_W)) u_presc (
        .clk(clk), .rst(rst), .run(run), .restart(load),
        .limit(presc_limit(active.rate)), .tick(tick));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= '{rate: RATE_OFF, count: '0};
            cnt     <= '0;
            ack_tgl <= 1'b0;
            end_tgl <= 1'b0;
        end else begin
            if (period_end) end_tgl <= ~end_tgl;
            if (load) begin
                active  <= cfg_hold;
                cnt     <= cfg_hold.count;
                ack_tgl <= req_s;
            end else if (tick) begin
                cnt <= (cnt == '0) ? active.count : cnt - 1'b1;
            end
        end
    end

    // R2: a wrap restarts the count from the adopted value with no idle cycle
    a_r2_back_to_back: assert property (@(posedge clk) disable iff (rst)
        period_end && !load |=> cnt == $past(active.count));

    // R3: an idle counter produces no period end
    a_r3_idle_no_end: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !period_end);

    // R6, R7, R8: a frozen, configured counter keeps its state
    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        !run && !stopped |=> $stable(cnt) && $stable(active));

    // R9: the adopted configuration only changes through the handshake
    a_r9_adopt_on_request: assert property (@(posedge clk) disable iff (rst)
        !pending |=> $stable(active));
endmodule

// File: rtl/tick_bus_regs.sv
`timescale 1ns/1ps
module tick_bus_regs
    import tick_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  period_cfg_t cfg_in,
    input  logic        ctl_we,
    input  logic        irq_en_in,
    input  freeze_ctl_t fctl_in,
    input  logic        flag_clr,
    input  logic        ack_tgl,
    input  logic        end_tgl,
    output period_cfg_t cfg_hold,
    output logic        req_tgl,
    output freeze_ctl_t fctl,
    output logic        irq_en,
    output logic        flag,
    output logic        busy
);
    logic ack_s, end_s, end_seen, set_pulse;

    tick_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s));
    tick_sync #(.W(1), .STAGES(SYNC_STAGES)) u_end_sync (
        .clk(clk), .rst(rst), .d(end_tgl), .q(end_s));

    assign set_pulse = (end_s != end_seen);
    assign busy      = (req_tgl != ack_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_hold <= '{rate: RATE_OFF, count: '0};
            req_tgl  <= 1'b0;
            fctl     <= '0;
            irq_en   <= 1'b0;
            flag     <= 1'b0;
            end_seen <= 1'b0;
        end else begin
            end_seen <= end_s;
            if (cfg_we && !busy) begin
                cfg_hold <= cfg_in;
                req_tgl  <= ~req_tgl;
            end
            if (ctl_we) begin
                irq_en <= irq_en_in;
                fctl   <= fctl_in;
            end
            if (set_pulse)     flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    // R5: a set event wins over a simultaneous clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> flag);

    // R5: a clear without a set event drops the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !set_pulse |=> !flag);

    // R9: an accepted write makes the block busy
    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we && !busy |=> busy);

    // R9: the held pair cannot change while a transfer is in flight
    a_r9_write_blocked: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_hold));
endmodule

// File: rtl/periodic_tick_timer.sv
`timescale 1ns/1ps
module periodic_tick_timer
    import tick_pkg::*;
(
    input  logic              clk_bus,
    input  logic              rst_bus,
    input  logic              clk_ref,
    input  logic              rst_ref,
    input  logic              cfg_we,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              ctl_we,
    input  logic              ctl_irq_en,
    input  logic              ctl_wait_freeze,
    input  logic              ctl_stop_run,
    input  logic              ctl_dbg_freeze,
    input  logic              flag_clr,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              debug_mode,
    output logic              timeout_flag,
    output logic              irq_req,
    output logic              cfg_busy
);
    period_cfg_t cfg_word, cfg_hold;
    freeze_ctl_t fctl_word, fctl;
    logic        req_tgl, ack_tgl, end_tgl, irq_en;

    assign cfg_word  = '{rate: rate_e'(cfg_rate), count: cfg_count};
    assign fctl_word = '{wait_freeze: ctl_wait_freeze, stop_run: ctl_stop_run,
                         dbg_freeze: ctl_dbg_freeze};

    tick_bus_regs u_regs (
        .clk(clk_bus), .rst(rst_bus),
        .cfg_we(cfg_we), .cfg_in(cfg_word),
        .ctl_we(ctl_we), .irq_en_in(ctl_irq_en), .fctl_in(fctl_word),
        .flag_clr(flag_clr), .ack_tgl(ack_tgl), .end_tgl(end_tgl),
        .cfg_hold(cfg_hold), .req_tgl(req_tgl), .fctl(fctl),
        .irq_en(irq_en), .flag(timeout_flag), .busy(cfg_busy));

    tick_ref_core u_core (
        .clk(clk_ref), .rst(rst_ref),
        .cfg_hold(cfg_hold), .req_tgl(req_tgl), .fctl_bus(fctl),
        .wait_mode(wait_mode), .stop_mode(stop_mode), .debug_mode(debug_mode),
        .ack_tgl(ack_tgl), .end_tgl(end_tgl));

    assign irq_req = timeout_flag && irq_en;

    // R4: no request without a pending timeout
    a_r4_irq_needs_flag: assert property (@(posedge clk_bus) disable iff (rst_bus)
        irq_req |-> timeout_flag);
endmodule

// File: tb/test_periodic_tick_timer.sv
`timescale 1ns/1ps
module test_periodic_tick_timer;
    localparam int BUS_PER_REF = 8;
    localparam int WD_LIMIT    = 190000;
    localparam int WAIT_MAX    = 20000;
    localparam int MODE_HOLD   = 300;

    logic clk_bus = 1'b0, clk_ref = 1'b0, rst_bus = 1'b1, rst_ref = 1'b1;
    logic cfg_we = 1'b0, ctl_we = 1'b0, flag_clr = 1'b0;
    logic [1:0] cfg_rate = '0;
    logic [7:0] cfg_count = '0;
    logic ctl_irq_en = 1'b0, ctl_wait_freeze = 1'b0, ctl_stop_run = 1'b0, ctl_dbg_freeze = 1'b0;
    logic wait_mode = 1'b0, stop_mode = 1'b0, debug_mode = 1'b0;
    logic timeout_flag, irq_req, cfg_busy;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always #2.5 clk_bus = ~clk_bus;
    initial begin
        #1.25;
        forever #20 clk_ref = ~clk_ref;
    end
    always @(posedge clk_bus) cyc <= cyc + 1;

    periodic_tick_timer i_periodic_tick_timer (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_ref(clk_ref), .rst_ref(rst_ref),
        .cfg_we(cfg_we), .cfg_rate(cfg_rate), .cfg_count(cfg_count),
        .ctl_we(ctl_we), .ctl_irq_en(ctl_irq_en), .ctl_wait_freeze(ctl_wait_freeze),
        .ctl_stop_run(ctl_stop_run), .ctl_dbg_freeze(ctl_dbg_freeze),
        .flag_clr(flag_clr), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .debug_mode(debug_mode), .timeout_flag(timeout_flag), .irq_req(irq_req),
        .cfg_busy(cfg_busy));

    function automatic int period_of(int rate, int n);
        int sh;
        sh = (rate == 1) ? 0 : (rate == 2) ? 4 : 8;
        return (n + 1) * (1 << sh) * BUS_PER_REF;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_range(string req, string what, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk_bus);
    endtask

    task automatic write_cfg(int rate, int n);
        @(negedge clk_bus);
        cfg_we = 1'b1; cfg_rate = 2'(rate); cfg_count = 8'(n);
        @(negedge clk_bus);
        cfg_we = 1'b0;
    endtask

    task automatic write_ctl(bit en, bit wf, bit sr, bit df);
        @(negedge clk_bus);
        ctl_we = 1'b1; ctl_irq_en = en; ctl_wait_freeze = wf;
        ctl_stop_run = sr; ctl_dbg_freeze = df;
        @(negedge clk_bus);
        ctl_we = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk_bus);
        flag_clr = 1'b0;
    endtask

    task automatic wait_flag_noclr(output int t);
        t = -1;
        for (int k = 0; k < WAIT_MAX; k++) begin
            @(negedge clk_bus);
            if (timeout_flag) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic wait_flag(output int t);
        wait_flag_noclr(t);
        pulse_clr();
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cfg_busy && n < WAIT_MAX) begin
            @(negedge clk_bus);
            n++;
        end
    endtask

    // R1, R2: adopt a pair, then measure two whole periods
    task automatic measure(int rate, int n);
        int t1, t2, t3, w;
        write_cfg(rate, n);
        wait_idle(w);
        idle(4);
        pulse_clr();
        wait_flag(t1);
        wait_flag(t2);
        wait_flag(t3);
        check("R1", $sformatf("period rate=%0d n=%0d", rate, n), t2 - t1, period_of(rate, n));
        check("R2", $sformatf("next period rate=%0d n=%0d", rate, n), t3 - t2, period_of(rate, n));
    endtask

    task automatic set_mode(int which, bit v);
        case (which)
            0: wait_mode = v;
            1: stop_mode = v;
            default: debug_mode = v;
        endcase
    endtask

    task automatic mode_case(string req, int which, bit frozen, int p);
        int t0, t1;
        wait_flag(t0);
        idle(100);
        set_mode(which, 1'b1);
        idle(MODE_HOLD);
        set_mode(which, 1'b0);
        wait_flag(t1);
        if (frozen)
            check_range(req, "frozen period stretch", t1 - t0,
                        p + MODE_HOLD - BUS_PER_REF, p + MODE_HOLD + BUS_PER_REF);
        else
            check(req, "running period", t1 - t0, p);
    endtask

    initial begin : watchdog
        wait (cyc >= WD_LIMIT);
        fails++;
        $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int t0, t1, t2, t3, w;
        bit seen;

        idle(40);
        rst_bus = 1'b0; rst_ref = 1'b0;
        idle(2);
        // R10: reset state
        check("R10", "flag after reset", int'(timeout_flag), 0);
        check("R10", "irq after reset", int'(irq_req), 0);
        check("R10", "busy after reset", int'(cfg_busy), 0);
        // R3, R10: idle counter yields no flag
        seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk_bus);
            if (timeout_flag) seen = 1;
        end
        check("R3", "flag while idle after reset", int'(seen), 0);

        // R9: write from idle, busy rises and the pair is adopted quickly
        write_cfg(1, 5);
        check("R9", "busy after accepted write", int'(cfg_busy), 1);
        wait_idle(w);
        check_range("R9", "idle adoption latency", w, 1, 64);

        // R1, R2: sweep rates and counts
        for (int n = 3; n <= 10; n++) measure(1, n);
        measure(1, 255);
        for (int n = 0; n <= 2; n++) measure(2, n);
        measure(3, 0);
        measure(3, 1);

        // R4, R5 with a 512-cycle period
        measure(2, 3);
        wait_flag_noclr(t0);
        check("R4", "irq while disabled", int'(irq_req), 0);
        write_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", "irq once enabled", int'(irq_req), 1);
        pulse_clr();
        check("R5", "flag after clear", int'(timeout_flag), 0);
        check("R4", "irq after clear", int'(irq_req), 0);
        flag_clr = 1'b1;
        seen = 0;
        for (int k = 0; k < 2 * period_of(2, 3) + 50; k++) begin
            @(negedge clk_bus);
            if (timeout_flag) seen = 1;
        end
        flag_clr = 1'b0;
        check("R5", "set wins over held clear", int'(seen), 1);
        write_ctl(1'b0, 1'b0, 1'b0, 1'b0);

        // R9: change at period boundary, second write ignored
        wait_flag(t0);
        write_cfg(1, 7);
        check("R9", "busy after switch write", int'(cfg_busy), 1);
        write_cfg(3, 0);
        wait_flag(t1);
        wait_flag(t2);
        wait_flag(t3);
        check("R9", "old period finishes", t1 - t0, period_of(2, 3));
        check("R9", "new period adopted", t2 - t1, period_of(1, 7));
        check("R9", "write during busy ignored", t3 - t2, period_of(1, 7));
        check("R9", "busy cleared", int'(cfg_busy), 0);

        // R6, R7, R8: freeze policies
        measure(2, 3);
        write_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        mode_case("R6", 0, 1'b1, period_of(2, 3));
        mode_case("R7", 1, 1'b1, period_of(2, 3));
        write_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        mode_case("R6", 0, 1'b0, period_of(2, 3));
        mode_case("R7", 1, 1'b0, period_of(2, 3));
        mode_case("R8", 2, 1'b1, period_of(2, 3));
        write_ctl(1'b0, 1'b0, 1'b1, 1'b0);
        mode_case("R8", 2, 1'b0, period_of(2, 3));

        // R3: return to idle, no further flags
        write_cfg(0, 0);
        wait_idle(w);
        idle(8);
        pulse_clr();
        seen = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk_bus);
            if (timeout_flag) seen = 1;
        end
        check("R3", "flag after switching to idle", int'(seen), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule